// File: doc/BRIEF.md
# Push-Button Burst Blinker

This block turns one push-button into a fixed, self-timed light pattern on one LED. A qualified press of the button launches a burst of five blinks. Each blink is one second lit followed by one second dark, so the burst lasts ten seconds. After the burst the LED stays dark and the block re-arms, waiting for the next press.

The raw button pin is first brought into the clock domain by a short flop chain. A debouncer then requires the level to hold steady for a set number of cycles before accepting it. Only a transition of the cleaned level from released to pressed counts as a press. All blink timing comes from a prescaler that makes a one-second tick out of the system clock, whose frequency is a parameter. A press restarts the prescaler, so the first lit phase begins at once and lasts a full second. A `busy` output shows when a burst is in progress. A testbench can shrink `CLK_HZ` so that a whole burst runs in a few hundred cycles.

Top module: `burst_blinker`

## Requirements
- R1: After reset, with no button press, `ledOut` and `busy` stay low.
- R2: A button level that rises and is held steady for at least `DEBOUNCE_CYCLES` cycles starts a burst. `ledOut` and `busy` go high no later than `DEBOUNCE_CYCLES`+4 clock cycles after the pin rises.
- R3: A button pulse shorter than `DEBOUNCE_CYCLES` cycles is rejected and starts nothing.
- R4: Within a burst, each blink has `ledOut` high for exactly `CLK_HZ` cycles (1 s), followed by `ledOut` low for exactly `CLK_HZ` cycles.
- R5: A burst contains exactly `BURST_BLINKS` (default 5) blinks, so it spans 2*`BURST_BLINKS`*`CLK_HZ` cycles (10 s at default).
- R6: When the last dark phase ends, `busy` falls, `ledOut` is already low, and the LED stays dark until a new press.
- R7: Presses made while a burst runs are ignored. They neither lengthen the burst nor start another burst after it.
- R8: Only a released-to-pressed transition starts a burst. A button still held when a burst ends starts nothing, and a later release and press starts a new burst.
- R9: `busy` is high for every cycle of a burst and for no other cycle, and `ledOut` is never high while `busy` is low.
- R10: A synchronous active-high `rst` clears the block on the next clock edge: `ledOut` and `busy` go low, including in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at `CLK_HZ` |
| rst | input | 1 | Synchronous reset, active high |
| buttonIn | input | 1 | Raw push-button level, high when pressed, asynchronous |
| ledOut | output | 1 | LED drive, high when lit |
| busy | output | 1 | High while a burst is in progress |

## Verification
The bound checker watches four things on every cycle. The LED is lit only while `busy` is high. No lit run is longer than one second. No burst is longer than its full span. A burst always begins with the LED lit and always ends with it dark. Some behaviour depends on what happens at the pin, so only directed scenarios can show it. These scenarios cover rejection of a short glitch, the exact blink count and phase lengths, presses ignored mid-burst without being queued, the need for a release between bursts, and a reset applied mid-burst.

// File: rtl/burst_blinker_pkg.sv
package burst_blinker_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LIT  = 2'd1,
    PH_DARK = 2'd2
  } phase_e;

  // control -> datapath
  typedef struct packed {
    logic restartTick;
    logic clearBlinks;
    logic countBlink;
  } ctrlStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic pressEdge;
    logic tick;
    logic lastBlink;
  } dpStatus_t;

endpackage

// File: rtl/burst_blinker_datapath.sv
module burst_blinker_datapath
  import burst_blinker_pkg::*;
#(
  parameter int CLK_HZ          = 50_000_000,
  parameter int DEBOUNCE_CYCLES = 1_000_000,
  parameter int BURST_BLINKS    = 5,
  parameter int SYNC_STAGES     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         buttonIn,
  input  ctrlStrobes_t strobes,
  output dpStatus_t    status
);

  localparam int DEB_W = $clog2(DEBOUNCE_CYCLES + 1);
  localparam logic [DEB_W-1:0] DEB_LAST = DEB_W'(DEBOUNCE_CYCLES - 1);
  localparam int BL_W = $clog2(BURST_BLINKS + 1);
  localparam logic [BL_W-1:0] BL_LAST = BL_W'(BURST_BLINKS - 1);

  // synchronizer chain
  logic [SYNC_STAGES-1:0] syncChain;
  logic syncBtn;

  always_ff @(posedge clk) begin
    if (rst) syncChain <= '0;
    else     syncChain <= {syncChain[SYNC_STAGES-2:0], buttonIn};
  end
  assign syncBtn = syncChain[SYNC_STAGES-1];

  // debouncer: accept a new level only after it holds DEBOUNCE_CYCLES cycles
  logic [DEB_W-1:0] debCnt;
  logic debState, debPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      debCnt   <= '0;
      debState <= 1'b0;
      debPrev  <= 1'b0;
    end else begin
      debPrev <= debState;
      if (syncBtn == debState) begin
        debCnt <= '0;
      end else if (debCnt == DEB_LAST) begin
        debState <= syncBtn;
        debCnt   <= '0;
      end else begin
        debCnt <= debCnt + 1'b1;
      end
    end
  end

  assign status.pressEdge = debState & ~debPrev;

  // one-second prescaler, restartable by the control
  generate
    if (CLK_HZ <= 1) begin : g_tickEveryCycle
      assign status.tick = 1'b1;
    end else begin : g_tickCounter
      localparam int PRE_W = $clog2(CLK_HZ);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_HZ - 1);
      logic [PRE_W-1:0] preCnt;

      always_ff @(posedge clk) begin
        if (rst || strobes.restartTick || preCnt == PRE_LAST) preCnt <= '0;
        else                                                  preCnt <= preCnt + 1'b1;
      end
      assign status.tick = (preCnt == PRE_LAST);
    end
  endgenerate

  // completed-blink counter
  logic [BL_W-1:0] blinkCnt;

  always_ff @(posedge clk) begin
    if (rst || strobes.clearBlinks) blinkCnt <= '0;
    else if (strobes.countBlink)    blinkCnt <= blinkCnt + 1'b1;
  end

  assign status.lastBlink = (blinkCnt == BL_LAST);

endmodule

// File: rtl/burst_blinker_ctrl.sv
module burst_blinker_ctrl
  import burst_blinker_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  dpStatus_t    status,
  output ctrlStrobes_t strobes,
  output logic         ledOut,
  output logic         busy
);

  phase_e phase, nextPhase;

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= nextPhase;
  end

  always_comb begin
    nextPhase = phase;
    strobes   = '0;
    case (phase)
      PH_IDLE: begin
        if (status.pressEdge) begin
          nextPhase           = PH_LIT;
          strobes.restartTick = 1'b1;
          strobes.clearBlinks = 1'b1;
        end
      end
      PH_LIT: begin
        if (status.tick) nextPhase = PH_DARK;
      end
      PH_DARK: begin
        if (status.tick) begin
          if (status.lastBlink) begin
            nextPhase = PH_IDLE;
          end else begin
            nextPhase          = PH_LIT;
            strobes.countBlink = 1'b1;
          end
        end
      end
      default: nextPhase = PH_IDLE;
    endcase
  end

  assign ledOut = (phase == PH_LIT);
  assign busy   = (phase != PH_IDLE);

endmodule

// File: rtl/burst_blinker.sv
module burst_blinker
  import burst_blinker_pkg::*;
#(
  parameter int CLK_HZ          = 50_000_000,
  parameter int DEBOUNCE_CYCLES = CLK_HZ / 50,
  parameter int BURST_BLINKS    = 5,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic buttonIn,
  output logic ledOut,
  output logic busy
);

  ctrlStrobes_t strobes;
  dpStatus_t    status;

  burst_blinker_datapath #(
    .CLK_HZ          (CLK_HZ),
    .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES),
    .BURST_BLINKS    (BURST_BLINKS),
    .SYNC_STAGES     (SYNC_STAGES)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .buttonIn (buttonIn),
    .strobes  (strobes),
    .status   (status)
  );

  burst_blinker_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .status  (status),
    .strobes (strobes),
    .ledOut  (ledOut),
    .busy    (busy)
  );

endmodule

// File: rtl/burst_blinker_chk.sv
module burst_blinker_chk #(
  parameter int CLK_HZ       = 50_000_000,
  parameter int BURST_BLINKS = 5
) (
  input logic clk,
  input logic rst,
  input logic ledOut,
  input logic busy
);

  localparam int BURST_CYCLES = 2 * BURST_BLINKS * CLK_HZ;

  int litRun;
  int busyRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      litRun  <= 0;
      busyRun <= 0;
    end else begin
      litRun  <= ledOut ? litRun + 1 : 0;
      busyRun <= busy ? busyRun + 1 : 0;
    end
  end

  // R9: LED never lit outside a burst
  a_r9_led_needs_busy: assert property (@(posedge clk) disable iff (rst)
    ledOut |-> busy);

  // R4: no lit phase longer than one second
  a_r4_lit_len: assert property (@(posedge clk) disable iff (rst)
    ledOut |-> (litRun < CLK_HZ));

  // R5: burst never outlasts its full span
  a_r5_burst_len: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busyRun < BURST_CYCLES));

  // R2: a burst begins with the LED lit
  a_r2_start_lit: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ledOut);

  // R6: a burst that ends normally ends dark
  a_r6_end_dark: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> !$past(ledOut));

  // R10: reset clears outputs on the next edge
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!busy && !ledOut));

endmodule

bind burst_blinker burst_blinker_chk #(
  .CLK_HZ       (CLK_HZ),
  .BURST_BLINKS (BURST_BLINKS)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .ledOut (ledOut),
  .busy   (busy)
);

// File: tb/burst_blinker_tb.sv
module burst_blinker_tb;

  localparam int CLK_HZ   = 40;
  localparam int DEB      = 6;
  localparam int BLINKS   = 5;
  localparam int BURST    = 2 * BLINKS * CLK_HZ;
  localparam int LAT_MAX  = DEB + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic buttonIn = 1'b0;
  logic ledOut, busy;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  burst_blinker #(
    .CLK_HZ          (CLK_HZ),
    .DEBOUNCE_CYCLES (DEB),
    .BURST_BLINKS    (BLINKS)
  ) u_dut (
    .clk      (clk),
    .rst      (rst),
    .buttonIn (buttonIn),
    .ledOut   (ledOut),
    .busy     (busy)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // count cycles in a window where led or busy is high
  task automatic watchDark(input int cycles, output int activeCycles);
    activeCycles = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (ledOut || busy) activeCycles++;
    end
  endtask

  // drive the button high and wait for the LED; returns negedges waited (-1 if none)
  task automatic pressAndWait(output int waited);
    buttonIn = 1'b1;
    waited = -1;
    for (int k = 1; k <= LAT_MAX + 20; k++) begin
      @(negedge clk);
      if (ledOut) begin
        waited = k;
        break;
      end
    end
  endtask

  // called on the first negedge with the LED lit; follows the burst to its end
  task automatic watchBurst(output int blinks, output int busyCycles,
                            output int badRuns, output int ledAtEnd);
    int run;
    logic prevLed;
    blinks = 1; busyCycles = 1; badRuns = 0; run = 1; prevLed = 1'b1; ledAtEnd = 0;
    for (int i = 0; i < BURST + 20; i++) begin
      @(negedge clk);
      if (!busy) begin
        ledAtEnd = int'(ledOut);
        break;
      end
      busyCycles++;
      if (ledOut == prevLed) begin
        run++;
      end else begin
        if (run != CLK_HZ) badRuns++;
        run = 1;
        if (ledOut) blinks++;
        prevLed = ledOut;
      end
    end
    if (run != CLK_HZ) badRuns++;
  endtask

  task automatic doReset();
    rst = 1'b1;
    buttonIn = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_idle();
    int act;
    doReset();
    @(negedge clk);
    check("R10 led after reset", int'(ledOut), 0);
    check("R10 busy after reset", int'(busy), 0);
    watchDark(3 * CLK_HZ, act);
    check("R1 idle with no press", act, 0);
  endtask

  task automatic t_glitch();
    int act;
    @(negedge clk);
    buttonIn = 1'b1;
    repeat (DEB - 1) @(negedge clk);
    buttonIn = 1'b0;
    watchDark(2 * DEB + CLK_HZ, act);
    check("R3 short pulse rejected", act, 0);
  endtask

  task automatic t_full_burst();
    int waited, blinks, busyCycles, badRuns, ledEnd, act;
    @(negedge clk);
    pressAndWait(waited);
    check("R2 burst started", int'(waited > 0 && waited <= LAT_MAX), 1);
    check("R2 busy with led", int'(busy), 1);
    buttonIn = 1'b0;
    watchBurst(blinks, busyCycles, badRuns, ledEnd);
    check("R4 phase lengths", badRuns, 0);
    check("R5 blink count", blinks, BLINKS);
    check("R9 busy span", busyCycles, BURST);
    check("R6 led dark at end", ledEnd, 0);
    watchDark(3 * CLK_HZ, act);
    check("R6 stays dark after burst", act, 0);
  endtask

  task automatic t_press_during();
    int waited, blinks, busyCycles, badRuns, ledEnd, act;
    @(negedge clk);
    pressAndWait(waited);
    check("R2 burst started", int'(waited > 0), 1);
    buttonIn = 1'b0;
    fork
      watchBurst(blinks, busyCycles, badRuns, ledEnd);
      begin
        repeat (3 * CLK_HZ) @(negedge clk);
        buttonIn = 1'b1;
        repeat (2 * DEB) @(negedge clk);
        buttonIn = 1'b0;
        repeat (2 * CLK_HZ) @(negedge clk);
        buttonIn = 1'b1;
        repeat (2 * DEB) @(negedge clk);
        buttonIn = 1'b0;
      end
    join
    check("R7 blink count unchanged", blinks, BLINKS);
    check("R7 burst not lengthened", busyCycles, BURST);
    watchDark(3 * CLK_HZ, act);
    check("R7 press not queued", act, 0);
  endtask

  task automatic t_hold_through();
    int waited, blinks, busyCycles, badRuns, ledEnd, act;
    @(negedge clk);
    pressAndWait(waited);
    check("R8 first burst started", int'(waited > 0), 1);
    watchBurst(blinks, busyCycles, badRuns, ledEnd);
    check("R8 held burst blink count", blinks, BLINKS);
    watchDark(3 * CLK_HZ, act);
    check("R8 held button no restart", act, 0);
    buttonIn = 1'b0;
    repeat (2 * DEB + 4) @(negedge clk);
    pressAndWait(waited);
    check("R8 re-press restarts", int'(waited > 0 && waited <= LAT_MAX), 1);
    buttonIn = 1'b0;
    watchBurst(blinks, busyCycles, badRuns, ledEnd);
    check("R8 re-press burst count", blinks, BLINKS);
  endtask

  task automatic t_reset_mid();
    int waited, act;
    @(negedge clk);
    pressAndWait(waited);
    buttonIn = 1'b0;
    check("R10 burst running before reset", int'(busy && waited > 0), 1);
    repeat (CLK_HZ / 2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R10 led cleared mid-burst", int'(ledOut), 0);
    check("R10 busy cleared mid-burst", int'(busy), 0);
    rst = 1'b0;
    watchDark(2 * CLK_HZ, act);
    check("R10 stays idle after reset", act, 0);
  endtask

  initial begin
    t_reset_idle();
    t_glitch();
    t_full_burst();
    t_press_during();
    t_hold_through();
    t_reset_mid();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule